// File: doc/BRIEF.md
# ADC Power and Sampling Sequencer

This block runs on a slow, always-on clock and drives a two-channel ADC. Once enabled, it takes the ADC out of power-down and waits a programmed warm-up interval. It then selects channel 0 and holds that selection until the ADC reports valid data, and does the same for channel 1. Each result is kept in a per-channel register. When both samples of a pair are in, the block issues a single-cycle evaluate pulse to the filter and debounce logic that sits outside it.

After every pair the sequencer picks the next kind of scan. With low-power mode off, it goes straight back to channel 0 and the ADC stays powered. With low-power mode on, it does the same only while the debounce logic reports that continuous scanning is wanted. In every other case it powers the ADC down and rests for a programmed number of slow-clock cycles, then begins again with warm-up. Clearing the enable stops the scan at once and powers the ADC down. A later enable always starts from warm-up.

Top module: `adc_scan_sequencer`

## Requirements
- R1: After reset and while `enable` is low, `adc_pd` is 1, `adc_chsel` is 0 and `eval_pulse` is 0. Reset clears both captured values to 0.
- R2: One cycle after `enable` is seen high in the idle state, `adc_pd` drops to 0. `adc_chsel` then stays 0 for max(`pwrup_cycles`,1) cycles, after which it becomes 1.
- R3: `adc_chsel` encodes 0 = not sampling, 1 = channel 0, 2 = channel 1, and never takes the value 3. It is 0 whenever `adc_pd` is 1.
- R4: `adc_chsel` stays 1 until a clock edge sees `adc_valid` high. At that edge `ch0_value` takes `adc_data`, and in the next cycle `adc_chsel` is 2.
- R5: `adc_chsel` stays 2 until a clock edge sees `adc_valid` high. At that edge `ch1_value` takes `adc_data`. In the next cycle `eval_pulse` is 1 for exactly one cycle and `adc_chsel` is 0.
- R6: An `adc_valid` strobe outside the matching sample state leaves both captured values unchanged. This covers idle, warm-up, rest and the other channel's sample state.
- R7: If `low_power` is 0 at the edge that ends the evaluate cycle, the next cycle shows `adc_chsel` = 1 and `adc_pd` = 0.
- R8: If `low_power` and `go_continuous` are both 1 at that edge, the next cycle also shows `adc_chsel` = 1 and `adc_pd` = 0.
- R9: If `low_power` is 1 and `go_continuous` is 0 at that edge, `adc_pd` is 1 for exactly max(`sleep_cycles`,1) cycles. A new warm-up as in R2 follows.
- R10: `enable` seen low at any edge gives `adc_pd` = 1 and `adc_chsel` = 0 in the next cycle. A later enable restarts the sequence at warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the sequencer |
| low_power | input | 1 | Allow periodic scanning with power-down |
| pwrup_cycles | input | PWR_W | ADC warm-up length in cycles |
| sleep_cycles | input | SLP_W | Rest length between periodic scans |
| go_continuous | input | 1 | Debounce logic asks to keep scanning continuously |
| adc_valid | input | 1 | ADC data valid strobe |
| adc_data | input | DW | ADC conversion result |
| adc_pd | output | 1 | ADC power-down |
| adc_chsel | output | 2 | ADC channel select (0 none, 1 ch0, 2 ch1) |
| ch0_value | output | DW | Last captured channel 0 sample |
| ch1_value | output | DW | Last captured channel 1 sample |
| eval_pulse | output | 1 | One-cycle pulse after each completed pair |

## Verification
Each output is decoded from a single state register, so every response shows up exactly one cycle after the edge that caused it. A captured value and the select step appear one cycle after the strobe edge. The evaluate pulse appears one cycle after the channel 1 strobe, and the scan-type decision one cycle after that. The bench drives inputs and samples outputs on the falling edge, so each check reads the state produced by the rising edge just before it. Warm-up and rest intervals are measured by counting falling edges while the output stays in its phase, and the count is compared with the clamped programmed length. Stray strobes are injected during warm-up, idle and the channel 0 state, and the captured values are read back afterwards.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int NUM_CH  = 2;
    localparam int CHSEL_W = 2;

    localparam logic [CHSEL_W-1:0] CHSEL_NONE = 2'd0;
    localparam logic [CHSEL_W-1:0] CHSEL_A    = 2'd1;
    localparam logic [CHSEL_W-1:0] CHSEL_B    = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WARM  = 3'd1,
        ST_PICK0 = 3'd2,
        ST_PICK1 = 3'd3,
        ST_EVAL  = 3'd4,
        ST_REST  = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic               pd;
        logic [CHSEL_W-1:0] chsel;
        logic               eval;
    } adc_drive_t;

    // Output drive decoded from the sequencer state.
    function automatic adc_drive_t drive_for(seq_state_e st);
        adc_drive_t d;
        d.pd    = 1'b0;
        d.chsel = CHSEL_NONE;
        d.eval  = 1'b0;
        case (st)
            ST_IDLE:  d.pd    = 1'b1;
            ST_REST:  d.pd    = 1'b1;
            ST_PICK0: d.chsel = CHSEL_A;
            ST_PICK1: d.chsel = CHSEL_B;
            ST_EVAL:  d.eval  = 1'b1;
            default:  d.pd    = 1'b0;
        endcase
        return d;
    endfunction

    // Sample state that belongs to a channel index.
    function automatic seq_state_e pick_state(int idx);
        return (idx == 0) ? ST_PICK0 : ST_PICK1;
    endfunction

    // Timed phases share one counter.
    function automatic logic is_timed(seq_state_e st);
        return (st == ST_WARM) || (st == ST_REST);
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q;
    logic [W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    // A limit of zero behaves as one cycle.
    assign expired = run && (cnt_inc >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clear || expired) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_inc[W-1:0];
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       low_power,
    input  logic       go_continuous,
    input  logic       adc_valid,
    input  logic       timer_expired,
    output seq_state_e state,
    output logic       timer_run,
    output logic       timer_clear,
    output logic       timer_sel_rest
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (enable) state_d = ST_WARM;
            ST_WARM:  if (timer_expired) state_d = ST_PICK0;
            ST_PICK0: if (adc_valid) state_d = ST_PICK1;
            ST_PICK1: if (adc_valid) state_d = ST_EVAL;
            ST_EVAL:  state_d = (!low_power || go_continuous) ? ST_PICK0 : ST_REST;
            ST_REST:  if (timer_expired) state_d = ST_WARM;
            default:  state_d = ST_IDLE;
        endcase
        if (!enable) begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state          = state_q;
    assign timer_run      = is_timed(state_q) && enable;
    assign timer_clear    = !is_timed(state_q);
    assign timer_sel_rest = (state_q == ST_REST);
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture
    import adc_seq_pkg::*;
#(
    parameter int DW = 10,
    parameter int NCH = NUM_CH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enable,
    input  seq_state_e              state,
    input  logic                    adc_valid,
    input  logic [DW-1:0]           adc_data,
    output logic [NCH-1:0][DW-1:0]  values
);
    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        localparam seq_state_e OWN_ST = pick_state(gi);
        logic [DW-1:0] val_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else if (enable && adc_valid && (state == OWN_ST)) begin
                val_q <= adc_data;
            end
        end

        assign values[gi] = val_q;
    end
endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
    import adc_seq_pkg::*;
#(
    parameter int PWR_W = 8,
    parameter int SLP_W = 16,
    parameter int DW    = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               low_power,
    input  logic [PWR_W-1:0]   pwrup_cycles,
    input  logic [SLP_W-1:0]   sleep_cycles,
    input  logic               go_continuous,
    input  logic               adc_valid,
    input  logic [DW-1:0]      adc_data,
    output logic               adc_pd,
    output logic [CHSEL_W-1:0] adc_chsel,
    output logic [DW-1:0]      ch0_value,
    output logic [DW-1:0]      ch1_value,
    output logic               eval_pulse
);
    localparam int CNT_W = (PWR_W > SLP_W) ? PWR_W : SLP_W;

    seq_state_e               state;
    logic                     timer_run;
    logic                     timer_clear;
    logic                     timer_sel_rest;
    logic                     timer_expired;
    logic [CNT_W-1:0]         timer_limit;
    logic [NUM_CH-1:0][DW-1:0] values;
    adc_drive_t               drive;

    assign timer_limit = timer_sel_rest ? CNT_W'(sleep_cycles) : CNT_W'(pwrup_cycles);

    adc_seq_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .enable         (enable),
        .low_power      (low_power),
        .go_continuous  (go_continuous),
        .adc_valid      (adc_valid),
        .timer_expired  (timer_expired),
        .state          (state),
        .timer_run      (timer_run),
        .timer_clear    (timer_clear),
        .timer_sel_rest (timer_sel_rest)
    );

    adc_seq_timer #(.W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (timer_clear),
        .run     (timer_run),
        .limit   (timer_limit),
        .expired (timer_expired)
    );

    adc_seq_capture #(.DW(DW), .NCH(NUM_CH)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .state     (state),
        .adc_valid (adc_valid),
        .adc_data  (adc_data),
        .values    (values)
    );

    assign drive      = drive_for(state);
    assign adc_pd     = drive.pd;
    assign adc_chsel  = drive.chsel;
    assign eval_pulse = drive.eval;
    assign ch0_value  = values[0];
    assign ch1_value  = values[1];
endmodule

// File: rtl/adc_scan_sequencer_chk.sv
module adc_scan_sequencer_chk
    import adc_seq_pkg::*;
#(
    parameter int DW = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               enable,
    input logic               low_power,
    input logic               go_continuous,
    input logic               adc_valid,
    input logic               adc_pd,
    input logic [CHSEL_W-1:0] adc_chsel,
    input logic               eval_pulse,
    input logic [DW-1:0]      ch0_value,
    input logic [DW-1:0]      ch1_value
);
    // R1 and R10: a low enable parks the ADC powered down
    assert_disable_parks_R1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (adc_pd && adc_chsel == CHSEL_NONE && !eval_pulse));

    assert_chsel_legal_R3: assert property (@(posedge clk) disable iff (rst)
        adc_chsel != 2'd3);

    assert_pd_no_select_R3: assert property (@(posedge clk) disable iff (rst)
        adc_pd |-> adc_chsel == CHSEL_NONE);

    assert_warmup_unselected_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_pd) |-> adc_chsel == CHSEL_NONE);

    assert_hold_ch0_R4: assert property (@(posedge clk) disable iff (rst)
        (adc_chsel == CHSEL_A && !adc_valid && enable) |=> adc_chsel == CHSEL_A);

    assert_eval_single_R5: assert property (@(posedge clk) disable iff (rst)
        eval_pulse |=> !eval_pulse);

    assert_eval_after_ch1_R5: assert property (@(posedge clk) disable iff (rst)
        eval_pulse |-> ($past(adc_valid) && $past(adc_chsel) == CHSEL_B));

    assert_ch0_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !(adc_valid && adc_chsel == CHSEL_A) |=> $stable(ch0_value));

    assert_ch1_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !(adc_valid && adc_chsel == CHSEL_B) |=> $stable(ch1_value));

    assert_continuous_R7: assert property (@(posedge clk) disable iff (rst)
        (eval_pulse && enable && !low_power) |=> (adc_chsel == CHSEL_A && !adc_pd));

    assert_forced_continuous_R8: assert property (@(posedge clk) disable iff (rst)
        (eval_pulse && enable && low_power && go_continuous) |=> (adc_chsel == CHSEL_A && !adc_pd));

    assert_periodic_rest_R9: assert property (@(posedge clk) disable iff (rst)
        (eval_pulse && enable && low_power && !go_continuous) |=> adc_pd);
endmodule

bind adc_scan_sequencer adc_scan_sequencer_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .low_power     (low_power),
    .go_continuous (go_continuous),
    .adc_valid     (adc_valid),
    .adc_pd        (adc_pd),
    .adc_chsel     (adc_chsel),
    .eval_pulse    (eval_pulse),
    .ch0_value     (ch0_value),
    .ch1_value     (ch1_value)
);

// File: tb/tb_adc_scan_sequencer.sv
`timescale 1ns/1ps
module tb_adc_scan_sequencer;
    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic        low_power;
    logic [7:0]  pwrup_cycles;
    logic [15:0] sleep_cycles;
    logic        go_continuous;
    logic        adc_valid;
    logic [9:0]  adc_data;
    logic        adc_pd;
    logic [1:0]  adc_chsel;
    logic [9:0]  ch0_value;
    logic [9:0]  ch1_value;
    logic        eval_pulse;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    adc_scan_sequencer dut (
        .clk(clk), .rst(rst), .enable(enable), .low_power(low_power),
        .pwrup_cycles(pwrup_cycles), .sleep_cycles(sleep_cycles),
        .go_continuous(go_continuous), .adc_valid(adc_valid), .adc_data(adc_data),
        .adc_pd(adc_pd), .adc_chsel(adc_chsel), .ch0_value(ch0_value),
        .ch1_value(ch1_value), .eval_pulse(eval_pulse)
    );

    function automatic int exp_len(int n);
        return (n == 0) ? 1 : n;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Starts at a falling edge in warm-up (from_pwrup) or channel 0 select.
    task automatic do_pair(input bit from_pwrup, input int np, input int ns,
                           input bit nlp, input bit ngc,
                           input logic [9:0] d0, input logic [9:0] d1,
                           input int l0, input int l1, output bit next_pwrup);
        int n;
        logic [9:0] old0, old1;
        old0 = ch0_value;
        old1 = ch1_value;
        if (from_pwrup) begin
            n = 0;
            while (adc_pd == 1'b0 && adc_chsel == 2'd0 && n < 1000) begin
                n++;
                if (n == 1) begin
                    adc_valid = 1'b1;
                    adc_data  = ~d0;
                end
                @(negedge clk);
                adc_valid = 1'b0;
            end
            check(n == exp_len(int'(pwrup_cycles)), "R2", "warm-up length", n, exp_len(int'(pwrup_cycles)));
            check(ch0_value == old0, "R6", "ch0 after stray strobe in warm-up", ch0_value, old0);
        end
        check(adc_chsel == 2'd1 && !adc_pd, "R4", "channel 0 select", adc_chsel, 1);
        pwrup_cycles  = 8'(np);
        sleep_cycles  = 16'(ns);
        low_power     = nlp;
        go_continuous = ngc;
        for (int i = 0; i < l0; i++) begin
            @(negedge clk);
            check(adc_chsel == 2'd1, "R4", "hold ch0 without valid", adc_chsel, 1);
        end
        adc_valid = 1'b1;
        adc_data  = d0;
        @(negedge clk);
        adc_valid = 1'b0;
        check(ch0_value == d0, "R4", "ch0 capture", ch0_value, d0);
        check(adc_chsel == 2'd2, "R3", "channel 1 select", adc_chsel, 2);
        check(ch1_value == old1, "R6", "ch1 unchanged by ch0 strobe", ch1_value, old1);
        for (int i = 0; i < l1; i++) begin
            @(negedge clk);
            check(adc_chsel == 2'd2 && !eval_pulse, "R5", "hold ch1 without valid", adc_chsel, 2);
        end
        adc_valid = 1'b1;
        adc_data  = d1;
        @(negedge clk);
        adc_valid = 1'b0;
        check(ch1_value == d1, "R5", "ch1 capture", ch1_value, d1);
        check(eval_pulse == 1'b1 && adc_chsel == 2'd0, "R5", "evaluate pulse", eval_pulse, 1);
        @(negedge clk);
        check(eval_pulse == 1'b0, "R5", "evaluate pulse width", eval_pulse, 0);
        if (!low_power || go_continuous) begin
            check(adc_chsel == 2'd1 && !adc_pd, low_power ? "R8" : "R7",
                  "continuous rescan", adc_chsel, 1);
            next_pwrup = 1'b0;
        end else begin
            check(adc_pd == 1'b1 && adc_chsel == 2'd0, "R9", "power-down after pair", adc_pd, 1);
            n = 0;
            while (adc_pd == 1'b1 && n < 100000) begin
                n++;
                @(negedge clk);
            end
            check(n == exp_len(int'(sleep_cycles)), "R9", "rest length", n, exp_len(int'(sleep_cycles)));
            next_pwrup = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1: actual=timeout expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit pw;
        void'($urandom(32'd2417));
        rst = 1'b1; enable = 1'b0; low_power = 1'b0; go_continuous = 1'b0;
        pwrup_cycles = 8'd0; sleep_cycles = 16'd0; adc_valid = 1'b0; adc_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(adc_pd == 1'b1 && adc_chsel == 2'd0 && !eval_pulse, "R1", "reset outputs", adc_pd, 1);
        check(ch0_value == 0 && ch1_value == 0, "R1", "reset values", ch0_value, 0);
        // stray strobes while idle
        for (int i = 0; i < 3; i++) begin
            adc_valid = 1'b1;
            adc_data  = 10'h2A5;
            @(negedge clk);
            check(adc_pd == 1'b1 && adc_chsel == 2'd0, "R1", "idle holds power-down", adc_pd, 1);
        end
        adc_valid = 1'b0;
        check(ch0_value == 0 && ch1_value == 0, "R6", "idle strobe ignored", ch0_value, 0);

        // directed: zero warm-up, then zero rest, then longer intervals
        enable = 1'b1;
        @(negedge clk);
        do_pair(1'b1, 3, 0, 1'b1, 1'b0, 10'h3FF, 10'h000, 0, 2, pw);
        do_pair(pw, 5, 4, 1'b1, 1'b0, 10'h000, 10'h3FF, 3, 0, pw);
        do_pair(pw, 2, 7, 1'b0, 1'b0, 10'h155, 10'h2AA, 1, 1, pw);
        do_pair(pw, 2, 7, 1'b1, 1'b1, 10'h0F0, 10'h30F, 0, 0, pw);
        do_pair(pw, 1, 3, 1'b1, 1'b0, 10'h001, 10'h200, 2, 1, pw);

        // constrained random scans
        for (int k = 0; k < 40; k++) begin
            do_pair(pw, $urandom_range(10, 0), $urandom_range(20, 0),
                    1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                    10'($urandom_range(1023, 0)), 10'($urandom_range(1023, 0)),
                    $urandom_range(3, 0), $urandom_range(3, 0), pw);
        end

        // disable mid-scan, then restart at warm-up
        enable = 1'b0;
        @(negedge clk);
        check(adc_pd == 1'b1 && adc_chsel == 2'd0, "R10", "disable powers down", adc_pd, 1);
        begin
            logic [9:0] h0, h1;
            h0 = ch0_value;
            h1 = ch1_value;
            for (int i = 0; i < 2; i++) begin
                adc_valid = 1'b1;
                adc_data  = ~h0;
                @(negedge clk);
                check(adc_pd == 1'b1, "R10", "stays powered down", adc_pd, 1);
            end
            adc_valid = 1'b0;
            check(ch0_value == h0 && ch1_value == h1, "R6", "disabled strobe ignored", ch0_value, h0);
        end
        pwrup_cycles = 8'd4;
        low_power = 1'b0;
        enable = 1'b1;
        @(negedge clk);
        check(adc_pd == 1'b0 && adc_chsel == 2'd0, "R10", "restart at warm-up", adc_chsel, 0);
        do_pair(1'b1, 4, 2, 1'b0, 1'b0, 10'h123, 10'h321, 1, 1, pw);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule